// File: doc/BRIEF.md
# Quadrature LO Generator with Per-Channel Phase Rotation

This block produces in-phase and quadrature local-oscillator square waves for eight demodulator channels. It runs on a timebase clock at sixteen times the LO rate. That is four times the rate of a reference clock, which itself runs at four times the LO rate. One reference period therefore spans four timebase cycles, and one LO period spans sixteen. A single shared 16-state counter marks the LO cycle. Each channel adds its own 4-bit phase code to that count, so the channel's waveform turns in 22.5-degree steps.

A synchronisation input lets several devices line up their LO phase. It must stay high for a full reference period before it acts. While it acts, the shared counter is held at zero and every output is forced low.

Phase changes are applied only at a channel's own period boundary. After any interruption, a channel's outputs stay low until its waveform reaches the start of a period. As a result the mixers never see a clipped pulse. A channel can also be switched off on its own without touching the others.

Top module: `qlo_gen`

## Requirements
- R1: With a channel enabled and its code steady, `lo_i_o` is a square wave with a period of 16 timebase cycles (four reference periods), high for 8 and low for 8.
- R2: The shared counter counts from 0 in the first cycle after reset release or after a hold ends, and advances by one each cycle modulo 16. A channel's index is (counter + code) mod 16, where the code is the channel's 4-bit unsigned field `phase_code_i[4*c +: 4]`. In the cycle that follows, `lo_i_o[c]` is high exactly when that index lies in 0..7. A larger code advances the phase by 22.5 degrees per step.
- R3: `lo_q_o[c]` is high exactly when the index lies in 4..11. It therefore lags `lo_i_o[c]` by 4 cycles (90 degrees) for every code.
- R4: `sync_i` acts only once it has been sampled high on 4 consecutive rising edges. A shorter pulse has no effect on any output.
- R5: On the 4th consecutive high sample of `sync_i`, and on each high sample after it, the counter is held at zero. All outputs are low in the following cycle.
- R6: A new code is adopted only in the cycle in which the channel's index is 15. After an adoption, or after a hold, a disable or a reset, the channel's outputs stay low until its index reaches 0. Every high pulse that is not cut short by a disable or a hold therefore lasts exactly 8 cycles.
- R7: When `ch_en_i[c]` is low, both outputs of channel c are low in the next cycle, and the channel takes its code directly from `phase_code_i`. The other channels and the shared counter are unaffected.
- R8: While `rst_ni` is low, all outputs are low at once (asynchronously) and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timebase clock, 16x LO rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Divider alignment request, synchronous to clk_i |
| ch_en_i | input | NUM_CH | Per-channel enable |
| phase_code_i | input | NUM_CH*PH_BITS | Packed per-channel phase codes, channel c at [PH_BITS*c +: PH_BITS] |
| lo_i_o | output | NUM_CH | In-phase LO per channel |
| lo_q_o | output | NUM_CH | Quadrature LO per channel |

## Verification
The assertions take `sync_i`, `ch_en_i` and `phase_code_i` to be synchronous to the timebase and to change only between clock edges. The exact-pulse-width checks also rely on every shortened pulse being caused by a disable or a hold in the preceding cycle. The stimulus changes all inputs half a period away from the active edge. It ends each high pulse early only through the enable or the sync input, and it changes codes at arbitrary offsets so that every code change has to pass through the boundary rule.

// File: rtl/qlo_pkg.sv
package qlo_pkg;
  localparam int unsigned DEF_NUM_CH  = 8;
  localparam int unsigned DEF_PH_BITS = 4;

  typedef enum logic {
    CH_WAIT = 1'b0,
    CH_RUN  = 1'b1
  } ch_st_e;
endpackage

// File: rtl/qlo_sync_qual.sv
module qlo_sync_qual #(
  parameter int unsigned QUAL_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_i,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(QUAL_LEN + 1);
  localparam logic [CW-1:0] RUN_MAX = CW'(QUAL_LEN - 1);

  logic [CW-1:0] run_q;

  // counts earlier consecutive high samples, saturating
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              run_q <= '0;
    else if (!sync_i)         run_q <= '0;
    else if (run_q != RUN_MAX) run_q <= run_q + CW'(1);
  end

  assign hold_o = sync_i && (run_q == RUN_MAX);
endmodule

// File: rtl/qlo_master_cnt.sv
module qlo_master_cnt #(
  parameter int unsigned PH_BITS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  output logic [PH_BITS-1:0] cnt_o
);
  logic [PH_BITS-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (hold_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + PH_BITS'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/qlo_chan.sv
module qlo_chan
  import qlo_pkg::*;
#(
  parameter int unsigned PH_BITS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               hold_i,
  input  logic               en_i,
  input  logic [PH_BITS-1:0] code_i,
  input  logic [PH_BITS-1:0] cnt_i,
  output logic               lo_i_o,
  output logic               lo_q_o
);
  localparam int unsigned STEPS = 1 << PH_BITS;
  localparam logic [PH_BITS-1:0] IDX_LAST = PH_BITS'(STEPS - 1);
  localparam logic [PH_BITS-1:0] IDX_HALF = PH_BITS'(STEPS / 2);
  localparam logic [PH_BITS-1:0] IDX_QTR  = PH_BITS'(STEPS / 4);

  logic [PH_BITS-1:0] code_q, idx, idx_quad;
  ch_st_e             st_q;
  logic               wait_eff, i_nxt, q_nxt, swap;
  logic               lo_i_q, lo_q_q;

  assign idx      = cnt_i + code_q;
  assign idx_quad = idx - IDX_QTR;
  // a waiting channel stays silent until its own period start
  assign wait_eff = (st_q == CH_WAIT) && (idx != '0);
  assign i_nxt    = !wait_eff && (idx < IDX_HALF);
  assign q_nxt    = !wait_eff && (idx_quad < IDX_HALF);
  assign swap     = (idx == IDX_LAST) && (code_i != code_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      st_q   <= CH_WAIT;
      lo_i_q <= 1'b0;
      lo_q_q <= 1'b0;
    end else if (hold_i || !en_i) begin
      code_q <= code_i;
      st_q   <= CH_WAIT;
      lo_i_q <= 1'b0;
      lo_q_q <= 1'b0;
    end else begin
      lo_i_q <= i_nxt;
      lo_q_q <= q_nxt;
      if (swap) begin
        code_q <= code_i;
        st_q   <= CH_WAIT;
      end else begin
        st_q   <= wait_eff ? CH_WAIT : CH_RUN;
      end
    end
  end

  assign lo_i_o = lo_i_q;
  assign lo_q_o = lo_q_q;
endmodule

// File: rtl/qlo_gen.sv
module qlo_gen
  import qlo_pkg::*;
#(
  parameter int unsigned NUM_CH  = DEF_NUM_CH,
  parameter int unsigned PH_BITS = DEF_PH_BITS
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        sync_i,
  input  logic [NUM_CH-1:0]           ch_en_i,
  input  logic [NUM_CH*PH_BITS-1:0]   phase_code_i,
  output logic [NUM_CH-1:0]           lo_i_o,
  output logic [NUM_CH-1:0]           lo_q_o
);
  // one reference period = a quarter of the timebase steps per LO period
  localparam int unsigned QUAL_LEN = (1 << PH_BITS) / 4;

  logic               hold;
  logic [PH_BITS-1:0] cnt;

  qlo_sync_qual #(.QUAL_LEN(QUAL_LEN)) u_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (sync_i),
    .hold_o (hold)
  );

  qlo_master_cnt #(.PH_BITS(PH_BITS)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hold_i (hold),
    .cnt_o  (cnt)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    qlo_chan #(.PH_BITS(PH_BITS)) u_ch (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .hold_i (hold),
      .en_i   (ch_en_i[c]),
      .code_i (phase_code_i[c*PH_BITS +: PH_BITS]),
      .cnt_i  (cnt),
      .lo_i_o (lo_i_o[c]),
      .lo_q_o (lo_q_o[c])
    );
  end
endmodule

// File: rtl/qlo_gen_chk.sv
module qlo_gen_chk #(
  parameter int unsigned NUM_CH  = 8,
  parameter int unsigned PH_BITS = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sync_i,
  input logic              hold_i,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic [NUM_CH-1:0] lo_i_i,
  input logic [NUM_CH-1:0] lo_q_i
);
  localparam int unsigned STEPS = 1 << PH_BITS;
  localparam int unsigned LW    = PH_BITS + 1;
  localparam logic [LW-1:0] L_HALF = LW'(STEPS / 2);
  localparam logic [LW-1:0] L_QTR  = LW'(STEPS / 4);
  localparam logic [LW-1:0] L_MAX  = LW'(STEPS);

  logic [LW-1:0] srun;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          srun <= '0;
    else if (!sync_i)     srun <= '0;
    else if (srun != L_QTR) srun <= srun + LW'(1);
  end

  AST_SYNC_QUALIFIED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> (srun >= L_QTR - LW'(1)));  // R4
  AST_HOLD_SILENCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (lo_i_i == '0 && lo_q_i == '0));  // R5

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    logic [LW-1:0] hi_i, hi_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_i <= '0;
        hi_q <= '0;
      end else begin
        hi_i <= !lo_i_i[c] ? '0 : (hi_i == L_MAX ? hi_i : hi_i + LW'(1));
        hi_q <= !lo_q_i[c] ? '0 : (hi_q == L_MAX ? hi_q : hi_q + LW'(1));
      end
    end

    AST_DISABLED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ch_en_i[c] |=> (!lo_i_i[c] && !lo_q_i[c]));  // R7
    AST_Q_RISES_AFTER_I: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lo_q_i[c]) |-> lo_i_i[c]);  // R3
    AST_I_RISES_Q_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lo_i_i[c]) |-> !lo_q_i[c]);  // R3
    AST_I_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(lo_i_i[c]) && $past(ch_en_i[c]) && !$past(hold_i)) |-> (hi_i == L_HALF));  // R6
    AST_Q_FULL_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($fell(lo_q_i[c]) && $past(ch_en_i[c]) && !$past(hold_i)) |-> (hi_q == L_HALF));  // R6
  end
endmodule

bind qlo_gen qlo_gen_chk #(.NUM_CH(NUM_CH), .PH_BITS(PH_BITS)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sync_i  (sync_i),
  .hold_i  (hold),
  .ch_en_i (ch_en_i),
  .lo_i_i  (lo_i_o),
  .lo_q_i  (lo_q_o)
);

// File: tb/sim_qlo_gen.sv
module sim_qlo_gen;
  localparam int NCH = 8;
  localparam int PB  = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             sync_r = 1'b0;
  logic [NCH-1:0]   en_r = '0;
  logic [NCH*PB-1:0] code_r = '0;
  logic [NCH-1:0]   lo_i_o, lo_q_o;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string tag = "R2";

  logic [2*NCH-1:0] sb[$];

  logic [PB-1:0] m_cnt;
  int            m_run;
  logic [PB-1:0] m_code[NCH];
  bit            m_wait[NCH];

  always #10 clk = ~clk;

  qlo_gen #(.NUM_CH(NCH), .PH_BITS(PB)) u0 (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .sync_i       (sync_r),
    .ch_en_i      (en_r),
    .phase_code_i (code_r),
    .lo_i_o       (lo_i_o),
    .lo_q_o       (lo_q_o)
  );

  function automatic logic [NCH*PB-1:0] mk_codes(int base, int mult);
    logic [NCH*PB-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*PB +: PB] = PB'((base + mult * c) % 16);
    return v;
  endfunction

  task automatic model_reset();
    m_cnt = '0;
    m_run = 0;
    for (int c = 0; c < NCH; c++) begin
      m_code[c] = '0;
      m_wait[c] = 1'b1;
    end
  endtask

  // expected outputs after the next rising edge, from the requirements
  task automatic model_push();
    logic [NCH-1:0] ei, eq;
    logic [PB-1:0]  idx, nc;
    bit act, w;
    act   = sync_r && (m_run == 3);
    m_run = sync_r ? ((m_run == 3) ? 3 : m_run + 1) : 0;
    for (int c = 0; c < NCH; c++) begin
      idx = PB'(m_cnt + m_code[c]);
      nc  = code_r[c*PB +: PB];
      if (act || !en_r[c]) begin
        ei[c] = 1'b0;
        eq[c] = 1'b0;
        m_code[c] = nc;
        m_wait[c] = 1'b1;
      end else begin
        w     = m_wait[c] && (idx != 0);
        ei[c] = !w && (idx < 8);
        eq[c] = !w && (idx >= 4) && (idx < 12);
        if (idx == 15 && nc != m_code[c]) begin
          m_code[c] = nc;
          m_wait[c] = 1'b1;
        end else begin
          m_wait[c] = w;
        end
      end
    end
    m_cnt = act ? '0 : PB'(m_cnt + 1);
    sb.push_back({eq, ei});
  endtask

  task automatic step(input logic s, input logic [NCH-1:0] en,
                      input logic [NCH*PB-1:0] codes, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      #1;
      sync_r = s;
      en_r   = en;
      code_r = codes;
      model_push();
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      logic [2*NCH-1:0] exp_v;
      exp_v = sb.pop_front();
      checks++;
      if ({lo_q_o, lo_i_o} !== exp_v) begin
        errors++;
        $display("FAIL %s actual q=%b i=%b expected q=%b i=%b", tag,
                 lo_q_o, lo_i_o, exp_v[2*NCH-1:NCH], exp_v[NCH-1:0]);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [NCH*PB-1:0] cset;
    repeat (3) @(negedge clk);
    checks++;  // R8 reset state
    if (lo_i_o !== '0 || lo_q_o !== '0) begin
      errors++;
      $display("FAIL R8 actual q=%b i=%b expected all zero", lo_q_o, lo_i_o);
    end

    cset = mk_codes(0, 2);
    @(negedge clk);
    #1;
    en_r   = '1;
    code_r = cset;
    rst_ni = 1'b1;
    model_reset();
    model_push();

    tag = "R2"; step(1'b0, '1, cset, 40);            // phase by code
    tag = "R1"; step(1'b0, '1, cset, 32);            // steady period
    tag = "R6"; step(1'b0, '1, mk_codes(3, 5), 45);  // change at odd offset
    tag = "R6"; step(1'b0, '1, mk_codes(9, 7), 37);
    tag = "R3"; step(1'b0, '1, mk_codes(9, 7), 40);  // quadrature steady
    tag = "R4"; step(1'b1, '1, mk_codes(9, 7), 3);   // too short
    step(1'b0, '1, mk_codes(9, 7), 30);
    tag = "R5"; step(1'b1, '1, mk_codes(1, 1), 6);   // qualified hold
    step(1'b0, '1, mk_codes(1, 1), 40);
    tag = "R7"; step(1'b0, 8'hDD, mk_codes(1, 1), 20);
    step(1'b0, 8'hDD, mk_codes(1, 3), 13);
    step(1'b0, '1, mk_codes(1, 3), 40);
    tag = "R6"; step(1'b0, '1, mk_codes(15, 9), 50);

    @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #2;
    checks++;  // R8 asynchronous clear
    if (lo_i_o !== '0 || lo_q_o !== '0) begin
      errors++;
      $display("FAIL R8 actual q=%b i=%b expected all zero", lo_q_o, lo_i_o);
    end
    repeat (2) @(negedge clk);
    checks++;  // R8 held
    if (lo_i_o !== '0 || lo_q_o !== '0) begin
      errors++;
      $display("FAIL R8 actual q=%b i=%b expected all zero", lo_q_o, lo_i_o);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule